// File: doc/BRIEF.md
# Associative Page Address Translator

This block turns a 20-bit virtual word address into a 14-bit physical address in a 16K-word core store that holds 48-bit words. The core store is divided into 32 frames of 512 words each. Every frame has one page register, which records the virtual page now resident in that frame and a valid bit. Each lookup compares the virtual page number against all 32 registers in the same cycle. A hit returns the matching frame index placed above the untranslated in-page offset.

A lookup that matches no valid register produces a miss response and raises a page-fault request to supervisor software. The faulting page number is captured and held until software acknowledges the fault. While a fault is pending the block accepts no new lookups, so the requester sees a stall. Software keeps the registers current through a maintenance port. It can load a page number and valid bit into a chosen frame, or invalidate a chosen frame, in a single cycle. Moving data to and from the backing store, choosing which frame to replace, and the core store itself are handled outside this block.

Top module: `pat_xlate`

## Requirements
- R1: The virtual address splits into an 11-bit page number in bits [19:9] and a 9-bit offset in bits [8:0]. On a hit, `rsp_paddr` is {frame index[4:0], offset[8:0]}, with the offset copied unchanged.
- R2: There are 32 frame registers, and any frame can hold any page. A lookup hits whichever valid frame holds the requested page, including frame 0 and frame 31.
- R3: After reset, every register is invalid, `rsp_valid` is 0, `flt_pend` is 0 and `lk_ready` is 1. Any lookup made after reset, for page 0 as well, misses.
- R4: When several valid frames hold the requested page, the response reports the lowest-numbered frame and sets `rsp_multi` to 1. A response with a single match has `rsp_multi` at 0.
- R5: A miss gives `rsp_valid`=1 and `rsp_hit`=0. In that same cycle `flt_pend` rises and `flt_page` holds the page number that missed.
- R6: `flt_pend` and `flt_page` hold steady until `flt_clr` is sampled high. `flt_pend` is 0 in the cycle after that.
- R7: While `flt_pend` is 1, `lk_ready` is 0. Any `lk_req` is ignored and produces no response, and it does not change `flt_page`.
- R8: A cycle with `mnt_we`=1 writes `mnt_page` and `mnt_valid` into frame `mnt_frame`, and lookups see the new contents from the next cycle on. An entry loaded with `mnt_valid`=0 never matches.
- R9: A cycle with `mnt_inv`=1 clears the valid bit of frame `mnt_frame`. If `mnt_we` is also 1 in that cycle, the invalidate wins.
- R10: A lookup accepted at a clock edge has its response one cycle later. If a lookup and a register write happen in the same cycle, the lookup is compared against the contents from before the write.
- R11: An invalid register never matches, even when its stored page equals the requested one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 20 | Virtual word address to translate |
| lk_ready | output | 1 | High when a lookup can be accepted (no fault pending) |
| rsp_valid | output | 1 | Lookup response present this cycle |
| rsp_hit | output | 1 | Response is a hit |
| rsp_multi | output | 1 | More than one frame matched |
| rsp_paddr | output | 14 | Physical address on a hit, zero on a miss |
| flt_pend | output | 1 | Page-fault interrupt request |
| flt_page | output | 11 | Page number that faulted |
| flt_clr | input | 1 | Software acknowledge that clears the pending fault |
| mnt_we | input | 1 | Load page and valid bit into the selected frame |
| mnt_inv | input | 1 | Invalidate the selected frame |
| mnt_frame | input | 5 | Frame register selected for maintenance |
| mnt_page | input | 11 | Page number to load |
| mnt_valid | input | 1 | Valid bit to load |

## Verification
The hardest state to reach from the ports is two valid frames holding the same page. Correct software never creates this. The bench creates it on purpose by loading a duplicate page into a higher frame. It then checks that the lower frame wins, and that the higher frame takes over once the lower entry is loaded invalid. The stall window while a fault is pending is also hard to observe, because it produces no output. The bench keeps `lk_req` high on pages that would hit during that window, and checks that no response appears and that `flt_page` does not move. Finally, the bench issues a lookup and a write to the same page in one cycle, to show that the lookup compares against the old contents.

// File: rtl/pat_pkg.sv
// Package: shared constants and the maintenance command type for the
// page address translator. Assumes nothing beyond IEEE 1800-2017.
package pat_pkg;

    // Default geometry: 512-word pages, 32 frames, 20-bit virtual space.
    localparam int unsigned PAT_VA_W   = 20;
    localparam int unsigned PAT_OFF_W  = 9;
    localparam int unsigned PAT_FRAMES = 32;

    // Maintenance command decoded once at the top and sent to every entry.
    typedef enum logic [1:0] {
        MNT_IDLE = 2'd0,
        MNT_LOAD = 2'd1,
        MNT_KILL = 2'd2
    } mnt_op_e;

endpackage

// File: rtl/pat_entry.sv
// Module: one frame register holding the resident page number and a valid
// bit, with its own comparator. Assumes the command and frame select are
// broadcast to all entries and that only the entry whose IDX equals the
// select acts on it. An invalid entry never reports a match.
module pat_entry
    import pat_pkg::*;
#(
    parameter int unsigned PG_W  = 11,
    parameter int unsigned IDX_W = 5,
    parameter int unsigned IDX   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mnt_op_e          op,
    input  logic [IDX_W-1:0] sel,
    input  logic [PG_W-1:0]  wr_page,
    input  logic             wr_valid,
    input  logic [PG_W-1:0]  cmp_page,
    output logic             match
);

    logic            vld_q;
    logic [PG_W-1:0] page_q;
    logic            mine;

    // Decode whether this entry is the maintenance target.
    assign mine = (sel == IDX_W'(IDX));

    // Hold the page and valid bit; an invalidate outranks a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            page_q <= '0;
        end else if (mine && op == MNT_KILL) begin
            vld_q  <= 1'b0;
        end else if (mine && op == MNT_LOAD) begin
            vld_q  <= wr_valid;
            page_q <= wr_page;
        end
    end

    // Compare the requested page against the stored one, gated by valid.
    always_comb begin
        match = vld_q && (page_q == cmp_page);
    end

    // R9: an invalidate leaves the entry invalid on the next cycle.
    p_kill_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mine && op == MNT_KILL) |=> !vld_q);

    // R8: a load stores exactly the page and valid bit that were offered.
    p_load_stores_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mine && op == MNT_LOAD) |=>
            (page_q == $past(wr_page) && vld_q == $past(wr_valid)));

    // R11: an entry that was invalid and untouched cannot match afterwards.
    p_invalid_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld_q && !(mine && op == MNT_LOAD)) |=> !match);

endmodule

// File: rtl/pat_pick.sv
// Module: fixed-priority selector over the match vector. Picks the lowest
// matching index, flags any match and flags more than one match.
// Purely combinational; assumes N is at most 2**IDX_W.
module pat_pick #(
    parameter int unsigned N     = 32,
    parameter int unsigned IDX_W = 5
) (
    input  logic [N-1:0]     hits,
    output logic             any,
    output logic             multi,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top down so that the lowest index is assigned last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    // Count the matches: any for one or more, multi for two or more.
    always_comb begin
        int unsigned cnt;
        cnt = 0;
        for (int i = 0; i < N; i++) begin
            cnt = cnt + int'(hits[i]);
        end
        any   = (cnt != 0);
        multi = (cnt > 1);
    end

endmodule

// File: rtl/pat_fault.sv
// Module: page-fault latch. Captures the missing page on a set, keeps it
// until software clears it. Assumes set is never raised while pending,
// because the top stops accepting lookups while a fault is pending.
module pat_fault #(
    parameter int unsigned PG_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set,
    input  logic [PG_W-1:0] set_page,
    input  logic            clr,
    output logic            pend,
    output logic [PG_W-1:0] page
);

    // Track the pending fault and the page number that caused it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            page <= '0;
        end else if (set) begin
            pend <= 1'b1;
            page <= set_page;
        end else if (pend && clr) begin
            pend <= 1'b0;
        end
    end

    // R6: without a clear, a pending fault and its page stay put.
    p_fault_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> (pend && $stable(page)));

    // R6: a clear while pending drops the request on the next cycle.
    p_fault_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && clr) |=> !pend);

    // R7: a second fault cannot be raised while one is pending.
    p_no_reset_while_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> !set);

endmodule

// File: rtl/pat_xlate.sv
// Module: associative page address translator (top). One register per
// core frame; each lookup compares the page against all of them at once
// and returns a registered result one cycle later. A miss raises a
// fault and stalls further lookups until software clears it.
// Assumes lk_vaddr is stable in the cycle lk_req is high.
module pat_xlate
    import pat_pkg::*;
#(
    parameter int unsigned VA_W   = PAT_VA_W,
    parameter int unsigned OFF_W  = PAT_OFF_W,
    parameter int unsigned FRAMES = PAT_FRAMES
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  lk_req,
    input  logic [VA_W-1:0]                       lk_vaddr,
    output logic                                  lk_ready,
    output logic                                  rsp_valid,
    output logic                                  rsp_hit,
    output logic                                  rsp_multi,
    output logic [$clog2(FRAMES)+OFF_W-1:0]       rsp_paddr,
    output logic                                  flt_pend,
    output logic [VA_W-OFF_W-1:0]                 flt_page,
    input  logic                                  flt_clr,
    input  logic                                  mnt_we,
    input  logic                                  mnt_inv,
    input  logic [$clog2(FRAMES)-1:0]             mnt_frame,
    input  logic [VA_W-OFF_W-1:0]                 mnt_page,
    input  logic                                  mnt_valid
);

    localparam int unsigned PG_W  = VA_W - OFF_W;
    localparam int unsigned IDX_W = $clog2(FRAMES);
    localparam int unsigned PA_W  = IDX_W + OFF_W;

    logic [PG_W-1:0]  req_page;
    logic [OFF_W-1:0] req_off;
    logic [FRAMES-1:0] hits;
    logic             any_hit;
    logic             many_hit;
    logic [IDX_W-1:0] hit_idx;
    logic             accept;
    mnt_op_e          op;

    // Split the virtual address into page number and offset.
    assign req_page = lk_vaddr[VA_W-1:OFF_W];
    assign req_off  = lk_vaddr[OFF_W-1:0];

    // Accept a lookup only when no fault is waiting for software.
    assign accept   = lk_req && !flt_pend;
    assign lk_ready = !flt_pend;

    // Turn the two maintenance strobes into one command; invalidate wins.
    always_comb begin
        if (mnt_inv) begin
            op = MNT_KILL;
        end else if (mnt_we) begin
            op = MNT_LOAD;
        end else begin
            op = MNT_IDLE;
        end
    end

    // One register and comparator per frame.
    for (genvar g = 0; g < FRAMES; g++) begin : g_frame
        pat_entry #(
            .PG_W (PG_W),
            .IDX_W(IDX_W),
            .IDX  (g)
        ) u_entry (
            .clk     (clk),
            .rst_n   (rst_n),
            .op      (op),
            .sel     (mnt_frame),
            .wr_page (mnt_page),
            .wr_valid(mnt_valid),
            .cmp_page(req_page),
            .match   (hits[g])
        );
    end

    pat_pick #(
        .N    (FRAMES),
        .IDX_W(IDX_W)
    ) u_pick (
        .hits (hits),
        .any  (any_hit),
        .multi(many_hit),
        .idx  (hit_idx)
    );

    pat_fault #(
        .PG_W(PG_W)
    ) u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (accept && !any_hit),
        .set_page(req_page),
        .clr     (flt_clr),
        .pend    (flt_pend),
        .page    (flt_page)
    );

    // Register the lookup result one cycle after the request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_multi <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_hit   <= any_hit;
                rsp_multi <= many_hit;
                rsp_paddr <= any_hit ? {hit_idx, req_off} : PA_W'(0);
            end
        end
    end

    // R1: on a hit the low bits equal the offset that was requested.
    p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_paddr[OFF_W-1:0] == $past(req_off)));

    // R4: the selected frame is one that actually matched.
    p_pick_member_r4: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> hits[hit_idx]);

    // R4: a multi-match flag only comes with a hit.
    p_multi_is_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_multi) |-> rsp_hit);

    // R5: a miss response comes with the fault request raised.
    p_miss_faults_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> flt_pend);

    // R7: a stalled cycle yields no response on the next one.
    p_stall_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flt_pend |=> !rsp_valid);

    // R10: every request taken produces a response one cycle later.
    p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_ready) |=> rsp_valid);

endmodule

// File: tb/tb_pat_xlate.sv
`timescale 1ns/1ps
// Bench: loads frame f with page 0x100+3f, walks a vector table of
// lookups, then runs directed tests for reset, multi-match, invalidate,
// stall and same-cycle write/lookup ordering.
module tb_pat_xlate;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_req;
    logic [19:0] lk_vaddr;
    logic        lk_ready;
    logic        rsp_valid;
    logic        rsp_hit;
    logic        rsp_multi;
    logic [13:0] rsp_paddr;
    logic        flt_pend;
    logic [10:0] flt_page;
    logic        flt_clr;
    logic        mnt_we;
    logic        mnt_inv;
    logic [4:0]  mnt_frame;
    logic [10:0] mnt_page;
    logic        mnt_valid;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pat_xlate dut (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_ready(lk_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_multi(rsp_multi),
        .rsp_paddr(rsp_paddr), .flt_pend(flt_pend), .flt_page(flt_page),
        .flt_clr(flt_clr), .mnt_we(mnt_we), .mnt_inv(mnt_inv),
        .mnt_frame(mnt_frame), .mnt_page(mnt_page), .mnt_valid(mnt_valid)
    );

    // Vector: {page[10:0], offset[8:0], expect_hit, expect_frame[4:0]}
    localparam logic [25:0] VEC [8] = '{
        {11'h100, 9'h000, 1'b1, 5'd0},
        {11'h103, 9'h1FF, 1'b1, 5'd1},
        {11'h15D, 9'h0AA, 1'b1, 5'd31},
        {11'h130, 9'h123, 1'b1, 5'd16},
        {11'h101, 9'h055, 1'b0, 5'd0},
        {11'h7FF, 9'h000, 1'b0, 5'd0},
        {11'h000, 9'h010, 1'b0, 5'd0},
        {11'h13F, 9'h001, 1'b1, 5'd21}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Issue one lookup and return after the response edge (sample at negedge).
    task automatic lookup(input logic [19:0] va);
        lk_req   = 1'b1;
        lk_vaddr = va;
        @(negedge clk);
        lk_req   = 1'b0;
    endtask

    task automatic load(input logic [4:0] fr, input logic [10:0] pg, input logic v);
        mnt_we = 1'b1; mnt_frame = fr; mnt_page = pg; mnt_valid = v;
        @(negedge clk);
        mnt_we = 1'b0;
    endtask

    task automatic clear_fault();
        flt_clr = 1'b1;
        @(negedge clk);
        flt_clr = 1'b0;
        check("R6 clear", {31'd0, flt_pend}, 32'd0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; lk_req = 1'b0; lk_vaddr = '0; flt_clr = 1'b0;
        mnt_we = 1'b0; mnt_inv = 1'b0; mnt_frame = '0; mnt_page = '0; mnt_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R3: reset state
        check("R3 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R3 flt_pend",  {31'd0, flt_pend},  32'd0);
        check("R3 lk_ready",  {31'd0, lk_ready},  32'd1);
        // R3 R11: page 0 equals the reset page value yet must miss
        lookup(20'h00005);
        check("R3 R11 miss after reset", {30'd0, rsp_valid, rsp_hit}, 32'd2);
        check("R5 fault page", {21'd0, flt_page}, 32'h000);
        clear_fault();

        for (int f = 0; f < 32; f++) load(5'(f), 11'(11'h100 + 3 * f), 1'b1);

        // R1 R2 R5 R10: table of lookups
        for (int i = 0; i < 8; i++) begin
            lookup({VEC[i][25:15], VEC[i][14:6]});
            check("R10 rsp_valid", {31'd0, rsp_valid}, 32'd1);
            check("R2 hit", {31'd0, rsp_hit}, {31'd0, VEC[i][5]});
            if (VEC[i][5]) begin
                check("R1 paddr", {18'd0, rsp_paddr}, {18'd0, VEC[i][4:0], VEC[i][14:6]});
                check("R4 single", {31'd0, rsp_multi}, 32'd0);
            end else begin
                check("R5 pend", {31'd0, flt_pend}, 32'd1);
                check("R5 page", {21'd0, flt_page}, {21'd0, VEC[i][25:15]});
                clear_fault();
            end
        end

        // R4: duplicate page in frame 9, lowest frame wins
        load(5'd9, 11'h100, 1'b1);
        lookup({11'h100, 9'h033});
        check("R4 lowest frame", {18'd0, rsp_paddr}, {18'd0, 5'd0, 9'h033});
        check("R4 multi flag", {31'd0, rsp_multi}, 32'd1);
        // R8 R11: frame 0 loaded invalid, frame 9 now serves
        load(5'd0, 11'h100, 1'b0);
        lookup({11'h100, 9'h044});
        check("R8 R11 invalid load", {17'd0, rsp_hit, rsp_paddr}, {17'd0, 1'b1, 5'd9, 9'h044});
        check("R4 single after", {31'd0, rsp_multi}, 32'd0);

        // R9: invalidate and load together on frame 9, invalidate wins
        mnt_inv = 1'b1; mnt_we = 1'b1; mnt_frame = 5'd9; mnt_page = 11'h100; mnt_valid = 1'b1;
        @(negedge clk);
        mnt_inv = 1'b0; mnt_we = 1'b0;
        lookup({11'h100, 9'h000});
        check("R9 invalidate wins", {31'd0, rsp_hit}, 32'd0);

        // R6 R7: fault pending, lookups stall and page stays
        lk_req = 1'b1; lk_vaddr = {11'h103, 9'h002};
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R7 no response", {31'd0, rsp_valid}, 32'd0);
            check("R7 not ready", {31'd0, lk_ready}, 32'd0);
            check("R6 page held", {21'd0, flt_page}, 32'h100);
        end
        lk_req = 1'b0;
        clear_fault();
        check("R7 ready again", {31'd0, lk_ready}, 32'd1);

        // R10: lookup and write in one cycle; lookup sees old contents
        lk_req = 1'b1; lk_vaddr = {11'h200, 9'h077};
        mnt_we = 1'b1; mnt_frame = 5'd5; mnt_page = 11'h200; mnt_valid = 1'b1;
        @(negedge clk);
        lk_req = 1'b0; mnt_we = 1'b0;
        check("R10 old contents", {30'd0, rsp_valid, rsp_hit}, 32'd2);
        clear_fault();
        lookup({11'h200, 9'h077});
        check("R8 new contents", {17'd0, rsp_hit, rsp_paddr}, {17'd0, 1'b1, 5'd5, 9'h077});

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule